// File: doc/BRIEF.md
# Sized memory access unit

This block serves one load or store at a time against a small byte-addressed physical memory that it holds itself. The memory size is a parameter. A requester presents a virtual address, an access size of one, two or four bytes, a write flag and write data. The block sends the virtual address to an external translation port and waits for that port to return either a physical address or a nonzero exception code.

When translation succeeds, the block reads or writes the bytes covered by the access. Multi-byte values are kept in memory least-significant byte first. Loads return the numeric value, zero-extended to 32 bits. When translation fails, the access is dropped before memory is touched, and the response carries the code and the virtual address that faulted. An illegal size code is reported at once, without any translation or access.

Top module: `mem_access_unit`

## Requirements
- R1: Size code 0 selects 1 byte, 1 selects 2 bytes and 2 selects 4 bytes. Code 3 is illegal. An accepted request with code 3 gives a response in the next cycle with rsp_illegal=1 and rsp_ok=0, raises no translation request and leaves memory unchanged.
- R2: A successful 1-byte store writes wdata[7:0] to the byte at the physical address and leaves every other byte unchanged.
- R3: A successful 2-byte store writes wdata[7:0] at the physical address and wdata[15:8] at the address plus one. Other bytes are unchanged.
- R4: A successful 4-byte store places wdata[8k+7:8k] at the physical address plus k, for k from 0 to 3.
- R5: A successful load returns the byte at the physical address plus k in bits [8k+7:8k] of rsp_rdata. The bits above the access width are zero.
- R6: When translation returns a nonzero exception code, memory is not modified. The response then has rsp_ok=0, rsp_exc equal to that code, rsp_vaddr equal to the faulting virtual address and rsp_rdata=0.
- R7: req_ready is high only while the block is idle. After a request is accepted, xlt_valid stays high with xlt_vaddr, xlt_write and xlt_size held until xlt_done. rsp_valid is high for exactly one cycle, in the cycle after the edge that samples xlt_done.
- R8: Byte lanes of a multi-byte access that pass the top of memory wrap to address 0, because addresses are taken modulo the memory size.
- R9: After reset, req_ready=1, xlt_valid=0, rsp_valid=0 and every memory byte reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_vaddr | input | VA_W | Virtual byte address |
| req_size | input | 2 | Size code: 0=1 byte, 1=2 bytes, 2=4 bytes, 3=illegal |
| req_write | input | 1 | 1 for store, 0 for load |
| req_wdata | input | 32 | Store data, right-aligned |
| xlt_valid | output | 1 | Translation requested |
| xlt_vaddr | output | VA_W | Address to translate |
| xlt_write | output | 1 | Access is a store |
| xlt_size | output | 2 | Size code of the access |
| xlt_done | input | 1 | Translation result valid |
| xlt_paddr | input | PA_W | Physical byte address |
| xlt_exc | input | EXC_W | Exception code, 0 means none |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_ok | output | 1 | Access completed |
| rsp_illegal | output | 1 | Request carried an illegal size code |
| rsp_exc | output | EXC_W | Exception code from translation |
| rsp_vaddr | output | VA_W | Virtual address of the request |
| rsp_rdata | output | 32 | Zero-extended load data |

## Verification
The embedded properties run on every cycle. They check the handshake timing, that illegal sizes are answered at once, that no write strobe fires unless translation reported no exception, that faulted responses carry no data, that narrow loads are zero-extended and that the lane count matches the size. Byte placement in memory, little-endian ordering, wrap at the top of memory and memory left untouched after faulted or illegal accesses can only be seen through the bench's store-then-load sequences, which compare the returned values with values computed by hand.

// File: rtl/mau_pkg.sv
package mau_pkg;
    localparam int DBYTES = 4;
    localparam int DW     = DBYTES * 8;

    typedef enum logic [1:0] {
        SZ_B   = 2'd0,
        SZ_H   = 2'd1,
        SZ_W   = 2'd2,
        SZ_BAD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XLT  = 2'd1,
        ST_RESP = 2'd2
    } state_e;
endpackage

// File: rtl/mau_lanes.sv
module mau_lanes
    import mau_pkg::*;
(
    input  size_e                sz,
    input  logic [DW-1:0]        wd,
    input  logic [DW-1:0]        raw,
    output logic [DBYTES-1:0]    be,
    output logic [DW-1:0]        wbytes,
    output logic [DW-1:0]        rext
);
    always_comb begin
        unique case (sz)
            SZ_B:    be = 4'b0001;
            SZ_H:    be = 4'b0011;
            SZ_W:    be = 4'b1111;
            default: be = 4'b0000;
        endcase
    end

    // lane k of the value goes to byte address base+k (least significant first)
    assign wbytes = wd;

    for (genvar k = 0; k < DBYTES; k++) begin : g_lane
        assign rext[8*k +: 8] = be[k] ? raw[8*k +: 8] : 8'h00;
    end

    always_comb begin
        if (sz != SZ_BAD && !$isunknown(sz))
            a_r1_lane_count: assert ($countones(be) == (1 << sz))
                else $error("lane count does not match size");
    end
endmodule

// File: rtl/mau_mem.sv
module mau_mem
    import mau_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    localparam int PA_W = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DBYTES-1:0] be,
    input  logic [PA_W-1:0]   addr,
    input  logic [DW-1:0]     wbytes,
    output logic [DW-1:0]     rbytes
);
    logic [7:0]      mem_q [MEM_BYTES];
    logic [PA_W-1:0] lane_addr [DBYTES];

    for (genvar k = 0; k < DBYTES; k++) begin : g_addr
        assign lane_addr[k] = addr + PA_W'(k);
        assign rbytes[8*k +: 8] = mem_q[lane_addr[k]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'h00;
        end else if (we) begin
            for (int k = 0; k < DBYTES; k++)
                if (be[k]) mem_q[lane_addr[k]] <= wbytes[8*k +: 8];
        end
    end

    a_r2_no_empty_write: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (be != '0));
endmodule

// File: rtl/mau_ctrl.sv
module mau_ctrl
    import mau_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int EXC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_size,
    input  logic             req_write,
    input  logic [DW-1:0]    req_wdata,
    output logic             xlt_valid,
    output logic [VA_W-1:0]  xlt_vaddr,
    output logic             xlt_write,
    output size_e            xlt_size,
    output logic [DW-1:0]    hold_wdata,
    input  logic             xlt_done,
    input  logic [EXC_W-1:0] xlt_exc,
    input  logic [DW-1:0]    rd_ext,
    output logic             mem_we,
    output logic             rsp_valid,
    output logic             rsp_ok,
    output logic             rsp_illegal,
    output logic [EXC_W-1:0] rsp_exc,
    output logic [VA_W-1:0]  rsp_vaddr,
    output logic [DW-1:0]    rsp_rdata
);
    typedef struct packed {
        state_e           st;
        logic [VA_W-1:0]  va;
        size_e            sz;
        logic             wr;
        logic [DW-1:0]    wd;
        logic             ok;
        logic             bad;
        logic [EXC_W-1:0] exc;
        logic [DW-1:0]    rd;
    } ctl_t;

    ctl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.va  = req_vaddr;
                    s_d.sz  = size_e'(req_size);
                    s_d.wr  = req_write;
                    s_d.wd  = req_wdata;
                    s_d.ok  = 1'b0;
                    s_d.exc = '0;
                    s_d.rd  = '0;
                    s_d.bad = (size_e'(req_size) == SZ_BAD);
                    s_d.st  = s_d.bad ? ST_RESP : ST_XLT;
                end
            end
            ST_XLT: begin
                if (xlt_done) begin
                    s_d.st  = ST_RESP;
                    s_d.exc = xlt_exc;
                    s_d.ok  = (xlt_exc == '0);
                    s_d.rd  = (xlt_exc == '0 && !s_q.wr) ? rd_ext : '0;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready   = (s_q.st == ST_IDLE);
    assign xlt_valid   = (s_q.st == ST_XLT);
    assign xlt_vaddr   = s_q.va;
    assign xlt_write   = s_q.wr;
    assign xlt_size    = s_q.sz;
    assign hold_wdata  = s_q.wd;
    assign mem_we      = (s_q.st == ST_XLT) && xlt_done && (xlt_exc == '0) && s_q.wr;
    assign rsp_valid   = (s_q.st == ST_RESP);
    assign rsp_ok      = s_q.ok;
    assign rsp_illegal = s_q.bad;
    assign rsp_exc     = s_q.exc;
    assign rsp_vaddr   = s_q.va;
    assign rsp_rdata   = s_q.rd;

    a_r1_illegal_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_size == 2'd3) |=> (rsp_valid && rsp_illegal && !rsp_ok && !xlt_valid));
    a_r7_resp_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (xlt_valid && xlt_done) |=> rsp_valid);
    a_r7_single_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));
    a_r7_xlt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xlt_valid && !xlt_done) |=> (xlt_valid && $stable(xlt_vaddr) && $stable(xlt_size) && $stable(xlt_write)));
    a_r6_fault_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc != '0) |-> (!rsp_ok && rsp_rdata == '0));
    a_r5_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok && xlt_size != SZ_W) |-> (rsp_rdata[DW-1:16] == '0));
endmodule

// File: rtl/mem_access_unit.sv
module mem_access_unit
    import mau_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    parameter int VA_W      = 32,
    parameter int EXC_W     = 3,
    localparam int PA_W     = $clog2(MEM_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_size,
    input  logic             req_write,
    input  logic [31:0]      req_wdata,
    output logic             xlt_valid,
    output logic [VA_W-1:0]  xlt_vaddr,
    output logic             xlt_write,
    output logic [1:0]       xlt_size,
    input  logic             xlt_done,
    input  logic [PA_W-1:0]  xlt_paddr,
    input  logic [EXC_W-1:0] xlt_exc,
    output logic             rsp_valid,
    output logic             rsp_ok,
    output logic             rsp_illegal,
    output logic [EXC_W-1:0] rsp_exc,
    output logic [VA_W-1:0]  rsp_vaddr,
    output logic [31:0]      rsp_rdata
);
    size_e             sz;
    logic [DW-1:0]     hold_wd, raw, rext, wbytes;
    logic [DBYTES-1:0] be;
    logic              mem_we;

    mau_ctrl #(.VA_W(VA_W), .EXC_W(EXC_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .xlt_valid(xlt_valid), .xlt_vaddr(xlt_vaddr), .xlt_write(xlt_write),
        .xlt_size(sz), .hold_wdata(hold_wd), .xlt_done(xlt_done), .xlt_exc(xlt_exc),
        .rd_ext(rext), .mem_we(mem_we),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_illegal(rsp_illegal),
        .rsp_exc(rsp_exc), .rsp_vaddr(rsp_vaddr), .rsp_rdata(rsp_rdata)
    );

    mau_lanes u_lanes (
        .sz(sz), .wd(hold_wd), .raw(raw), .be(be), .wbytes(wbytes), .rext(rext)
    );

    mau_mem #(.MEM_BYTES(MEM_BYTES)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .be(be), .addr(xlt_paddr),
        .wbytes(wbytes), .rbytes(raw)
    );

    assign xlt_size = sz;

    a_r6_no_write_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (xlt_valid && xlt_done && xlt_exc == '0 && xlt_write));
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!xlt_valid && !rsp_valid));
endmodule

// File: tb/mem_access_unit_bench.sv
module mem_access_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_vaddr = '0, req_wdata = '0;
    logic [1:0]  req_size = '0;
    logic        xlt_done = 1'b0;
    logic [7:0]  xlt_paddr = '0;
    logic [2:0]  xlt_exc = '0;
    logic        req_ready, xlt_valid, xlt_write, rsp_valid, rsp_ok, rsp_illegal;
    logic [31:0] xlt_vaddr, rsp_vaddr, rsp_rdata;
    logic [1:0]  xlt_size;
    logic [2:0]  rsp_exc;

    int checks = 0, failures = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    mem_access_unit u_mem_access_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .xlt_valid(xlt_valid), .xlt_vaddr(xlt_vaddr), .xlt_write(xlt_write), .xlt_size(xlt_size),
        .xlt_done(xlt_done), .xlt_paddr(xlt_paddr), .xlt_exc(xlt_exc),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_illegal(rsp_illegal),
        .rsp_exc(rsp_exc), .rsp_vaddr(rsp_vaddr), .rsp_rdata(rsp_rdata)
    );

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  sz;
        logic        wr;
        logic [31:0] wd;
        logic [7:0]  pa;
        logic [2:0]  exc;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{32'h1000, 2'd2, 1'b1, 32'h11223344, 8'h10, 3'd0, 32'h0},
        '{32'h1000, 2'd0, 1'b0, 32'h0,        8'h10, 3'd0, 32'h44},
        '{32'h1003, 2'd0, 1'b0, 32'h0,        8'h13, 3'd0, 32'h11},
        '{32'h1002, 2'd1, 1'b0, 32'h0,        8'h12, 3'd0, 32'h1122},
        '{32'h1000, 2'd2, 1'b0, 32'h0,        8'h10, 3'd0, 32'h11223344},
        '{32'h1001, 2'd0, 1'b1, 32'hAABBCCDD, 8'h11, 3'd0, 32'h0},
        '{32'h1000, 2'd2, 1'b0, 32'h0,        8'h10, 3'd0, 32'h1122DD44},
        '{32'h1002, 2'd1, 1'b1, 32'hFFFF5566, 8'h12, 3'd0, 32'h0},
        '{32'h1000, 2'd2, 1'b0, 32'h0,        8'h10, 3'd0, 32'h5566DD44},
        '{32'h1000, 2'd2, 1'b1, 32'h0,        8'h10, 3'd3, 32'h0},
        '{32'h1000, 2'd2, 1'b0, 32'h0,        8'h10, 3'd0, 32'h5566DD44},
        '{32'h2000, 2'd2, 1'b0, 32'h0,        8'h10, 3'd5, 32'h0},
        '{32'h30FE, 2'd2, 1'b1, 32'hCAFEBABE, 8'hFE, 3'd0, 32'h0},
        '{32'h3100, 2'd1, 1'b0, 32'h0,        8'h00, 3'd0, 32'hCAFE},
        '{32'h30FE, 2'd1, 1'b0, 32'h0,        8'hFE, 3'd0, 32'hBABE},
        '{32'h30FF, 2'd2, 1'b0, 32'h0,        8'hFF, 3'd0, 32'h00CAFEBA},
        '{32'h4020, 2'd2, 1'b0, 32'h0,        8'h20, 3'd0, 32'h0},
        '{32'h1001, 2'd0, 1'b1, 32'h000000FF, 8'h11, 3'd1, 32'h0},
        '{32'h1001, 2'd0, 1'b0, 32'h0,        8'h11, 3'd0, 32'hDD}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.exc != 0) return "R6";
        if (v.va[15:8] == 8'h30 || v.va[15:8] == 8'h31) return "R8";
        if (!v.wr) return (v.va[15:12] == 4'h4) ? "R9" : "R5";
        case (v.sz)
            2'd0: return "R2";
            2'd1: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic access(input vec_t v, input int delay, input string tg);
        @(negedge clk);
        chk(req_ready, "R7 ready when idle", {31'b0, req_ready}, 32'h1);
        req_valid = 1'b1; req_vaddr = v.va; req_size = v.sz;
        req_write = v.wr; req_wdata = v.wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (v.sz == 2'd3) begin
            chk(rsp_valid && rsp_illegal && !rsp_ok && !xlt_valid, "R1 illegal response",
                {28'b0, rsp_valid, rsp_illegal, rsp_ok, xlt_valid}, 32'hC);
            @(negedge clk);
            chk(!rsp_valid && req_ready, "R7 back to idle", {31'b0, rsp_valid}, 32'h0);
            return;
        end
        chk(xlt_valid && !req_ready && xlt_vaddr == v.va && xlt_size == v.sz && xlt_write == v.wr,
            "R7 translation request", xlt_vaddr, v.va);
        repeat (delay) @(negedge clk);
        chk(xlt_valid && !rsp_valid && xlt_vaddr == v.va, "R7 held while waiting",
            {30'b0, xlt_valid, rsp_valid}, 32'h2);
        xlt_done = 1'b1; xlt_paddr = v.pa; xlt_exc = v.exc;
        @(negedge clk);
        xlt_done = 1'b0; xlt_exc = '0;
        chk(rsp_valid, {tg, " response valid"}, {31'b0, rsp_valid}, 32'h1);
        chk(rsp_ok == (v.exc == 0) && rsp_exc == v.exc && !rsp_illegal, {tg, " status"},
            {28'b0, rsp_ok, rsp_exc}, {28'b0, (v.exc == 0), v.exc});
        chk(rsp_vaddr == v.va, {tg, " address echo"}, rsp_vaddr, v.va);
        chk(rsp_rdata == v.exp, {tg, " read data"}, rsp_rdata, v.exp);
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R7 one-cycle response", {31'b0, rsp_valid}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        vec_t v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        chk(req_ready && !xlt_valid && !rsp_valid, "R9 reset outputs",
            {29'b0, req_ready, xlt_valid, rsp_valid}, 32'h4);

        for (int i = 0; i < NV; i++) access(VECS[i], i % 3, tag_of(VECS[i]));

        // R1: illegal store must not touch byte 0x10..0x13, and asks for no translation
        v = '{32'h1000, 2'd3, 1'b1, 32'hDEADBEEF, 8'h10, 3'd0, 32'h0};
        access(v, 0, "R1");
        v = '{32'h1000, 2'd2, 1'b0, 32'h0, 8'h10, 3'd0, 32'h5566DD44};
        access(v, 1, "R1");

        // R6: faulted half store with long translation wait, then readback
        v = '{32'h1012, 2'd1, 1'b1, 32'h0000ABCD, 8'h12, 3'd7, 32'h0};
        access(v, 5, "R6");
        v = '{32'h1012, 2'd1, 1'b0, 32'h0, 8'h12, 3'd0, 32'h5566};
        access(v, 0, "R6");

        // R7: request held during busy is not taken until idle
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h5000; req_size = 2'd0; req_write = 1'b0;
        @(negedge clk);
        chk(xlt_valid && !req_ready, "R7 busy blocks ready", {31'b0, req_ready}, 32'h0);
        xlt_done = 1'b1; xlt_paddr = 8'h13; xlt_exc = '0;
        @(negedge clk);
        xlt_done = 1'b0; req_valid = 1'b0;
        chk(rsp_valid && rsp_rdata == 32'h55, "R7 response one cycle after done", rsp_rdata, 32'h55);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule